// File: doc/BRIEF.md
# Exchange Port Connection Sequencer

This block is the per-port agent of a circuit-switched message exchange. Each instance owns one input/output pair of a crossbar, serves a local byte source and a local byte sink, and sits on a daisy-chained control ring that it shares with a central controller. It keeps a three-state view of its crossbar path: inactive, pending or active. It also remembers the node it is currently wired to, called the partner.

Local messages are addressed by a destination byte. If the path to that destination already exists, the message goes straight into the crossbar, stamped with the port's own identifier. If not, the port keeps the message and puts a request on the ring. It then waits until an acknowledge for its own request passes by, and only then releases the stored message. Every ring packet is passed on unchanged to the next node. Release and acknowledge packets can move the port between states, and the port acts on a packet only after the whole packet has been forwarded. All six interfaces are byte-wide valid/ready streams.

Top module: `exn_port`

## Requirements
- R1: After reset the port is inactive, its partner is the nil code 8'hFF, and none of its three output streams asserts valid.
- R2: When several inputs are waiting, the port serves them in a fixed order: crossbar input first, ring input second, local input last. The local input is never accepted while the port is pending.
- R3: A crossbar message has the form source, length L, then L payload bytes. It is copied unchanged to the local sink.
- R4: Ring packets begin with a token byte. Token 8'h01 is a request (token, source, destination). Token 8'h02 is an acknowledge (token, source, destination). Token 8'h03 is a release (token, partner A, partner B, source, destination). Any other token is a one-byte packet. Every packet is forwarded unchanged and completely before it has any effect.
- R5: A local message has the form destination, length L, then L payload bytes. If the port is active and the destination equals the partner, the port sends its identifier, the length and the payload into the crossbar.
- R6: Any other accepted local message is stored. The port then emits the request 8'h01, identifier, destination on the ring and becomes pending.
- R7: Local payload beyond MSG_MAX bytes is consumed and discarded, and the length sent on is min(L, MSG_MAX).
- R8: An active port becomes inactive on a release that carries its identifier in partner A, partner B or destination. The exception is a release whose source equals the partner and whose destination equals the identifier.
- R9: An inactive port becomes active on an acknowledge whose destination is its identifier, and takes the acknowledge's source as its partner.
- R10: A pending port that sees an acknowledge whose source is its identifier sends the stored message into the crossbar, becomes active, and takes the acknowledge's destination as its partner.
- R11: Request packets, unknown tokens and acknowledges that match neither rule leave the state and the partner unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_in_valid | input | 1 | Ring byte from previous node is valid |
| ring_in_ready | output | 1 | Port takes the ring byte |
| ring_in_data | input | 8 | Ring byte from previous node |
| ring_out_valid | output | 1 | Ring byte to next node is valid |
| ring_out_ready | input | 1 | Next node takes the ring byte |
| ring_out_data | output | 8 | Ring byte to next node |
| loc_in_valid | input | 1 | Local outgoing byte is valid |
| loc_in_ready | output | 1 | Port takes the local byte |
| loc_in_data | input | 8 | Local outgoing byte |
| loc_out_valid | output | 1 | Byte to local sink is valid |
| loc_out_ready | input | 1 | Local sink takes the byte |
| loc_out_data | output | 8 | Byte to local sink |
| xb_in_valid | input | 1 | Byte from crossbar output is valid |
| xb_in_ready | output | 1 | Port takes the crossbar byte |
| xb_in_data | input | 8 | Byte from crossbar output |
| xb_out_valid | output | 1 | Byte to crossbar input is valid |
| xb_out_ready | input | 1 | Crossbar takes the byte |
| xb_out_data | output | 8 | Byte to crossbar input |

## Verification
The bench targets the release exception, in which the sender is the partner and the destination is this port. A design that ignores the exception drops a live path, and the next local message to the partner shows up as a ring request instead of crossbar traffic. It also presents all three inputs in the same cycle while the port is active. A wrong arbitration order either forwards ring bytes before the crossbar message, or routes the local message through the crossbar before the deactivating release has been seen. Further cases are acknowledges that arrive while the port is pending but name it only as the destination (a sloppy design would wake up on them), local messages longer than the buffer (a wrong design corrupts the length or loses framing), and a local byte held at the input while the port is pending (it must never be taken).

// File: rtl/exn_pkg.sv
package exn_pkg;

    typedef enum logic [1:0] {
        CS_INACTIVE = 2'd0,
        CS_PENDING  = 2'd1,
        CS_ACTIVE   = 2'd2
    } conn_e;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_XB       = 3'd1,
        PH_RING     = 3'd2,
        PH_RING_ACT = 3'd3,
        PH_LOC      = 3'd4,
        PH_LOC_DEC  = 3'd5,
        PH_REQ      = 3'd6,
        PH_SEND     = 3'd7
    } phase_e;

    localparam logic [7:0] TOK_REQ  = 8'h01;
    localparam logic [7:0] TOK_ACK  = 8'h02;
    localparam logic [7:0] TOK_REL  = 8'h03;
    localparam logic [7:0] NIL_NODE = 8'hFF;

endpackage

// File: rtl/exn_msg_buf.sv
module exn_msg_buf #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R7: stores never land outside the message buffer
    always_ff @(posedge clk) begin
        if (we) begin
            p_waddr_in_range_r7: assert (int'(waddr) < DEPTH)
                else $error("buffer write outside depth");
        end
    end

endmodule

// File: rtl/exn_ring_parse.sv
module exn_ring_parse
    import exn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stb_i,
    input  logic [7:0] byte_i,
    output logic       last_o,
    output logic [7:0] tok_o,
    output logic [7:0] a1_o,
    output logic [7:0] a2_o,
    output logic [7:0] src_o,
    output logic [7:0] dst_o
);

    typedef struct packed {
        logic [2:0] idx;
        logic [7:0] tok;
        logic [7:0] a1;
        logic [7:0] a2;
        logic [7:0] src;
        logic [7:0] dst;
    } parse_t;

    parse_t q, d;
    logic [7:0] cur_tok;
    logic [2:0] pkt_len;

    always_comb begin
        d       = q;
        cur_tok = (q.idx == 3'd0) ? byte_i : q.tok;
        case (cur_tok)
            TOK_REL:          pkt_len = 3'd5;
            TOK_REQ, TOK_ACK: pkt_len = 3'd3;
            default:          pkt_len = 3'd1;
        endcase
        last_o = (q.idx == pkt_len - 3'd1);
        if (stb_i) begin
            if (q.idx == 3'd0) begin
                d.tok = byte_i;
            end
            if (cur_tok == TOK_REL) begin
                case (q.idx)
                    3'd1:    d.a1  = byte_i;
                    3'd2:    d.a2  = byte_i;
                    3'd3:    d.src = byte_i;
                    3'd4:    d.dst = byte_i;
                    default: ;
                endcase
            end else begin
                case (q.idx)
                    3'd1:    d.src = byte_i;
                    3'd2:    d.dst = byte_i;
                    default: ;
                endcase
            end
            d.idx = last_o ? 3'd0 : q.idx + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tok_o = q.tok;
    assign a1_o  = q.a1;
    assign a2_o  = q.a2;
    assign src_o = q.src;
    assign dst_o = q.dst;

    // R4: a release token never closes its packet on the first byte
    p_rel_not_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i && q.idx == 3'd0 && byte_i == TOK_REL |-> !last_o);

    // R4: after a closing byte the next packet starts at its token
    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb_i && last_o |=> q.idx == 3'd0);

endmodule

// File: rtl/exn_conn_track.sv
module exn_conn_track
    import exn_pkg::*;
#(
    parameter int           IDW = 5,
    parameter logic [IDW-1:0] ID = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_i,
    input  logic [7:0] tok_i,
    input  logic [7:0] a1_i,
    input  logic [7:0] a2_i,
    input  logic [7:0] src_i,
    input  logic [7:0] dst_i,
    input  logic       go_pend_i,
    output conn_e      st_o,
    output logic [7:0] partner_o,
    output logic       fire_o
);

    localparam logic [7:0] OWN = 8'(ID);

    typedef struct packed {
        conn_e      st;
        logic [7:0] partner;
    } trk_t;

    trk_t q, d;
    logic names_me;
    logic keeps_path;

    always_comb begin
        d          = q;
        fire_o     = 1'b0;
        names_me   = (a1_i == OWN) || (a2_i == OWN) || (dst_i == OWN);
        keeps_path = (src_i == q.partner) && (dst_i == OWN);
        if (ev_i) begin
            if (tok_i == TOK_REL) begin
                if (q.st == CS_ACTIVE && names_me && !keeps_path) begin
                    d.st = CS_INACTIVE;
                end
            end else if (tok_i == TOK_ACK) begin
                if (q.st == CS_INACTIVE && dst_i == OWN) begin
                    d.st      = CS_ACTIVE;
                    d.partner = src_i;
                end else if (q.st == CS_PENDING && src_i == OWN) begin
                    fire_o    = 1'b1;
                    d.st      = CS_ACTIVE;
                    d.partner = dst_i;
                end
            end
        end else if (go_pend_i) begin
            d.st = CS_PENDING;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= CS_INACTIVE;
            q.partner <= NIL_NODE;
        end else begin
            q <= d;
        end
    end

    assign st_o      = q.st;
    assign partner_o = q.partner;

    // R6: pending is left only through an acknowledge of this port's request
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == CS_PENDING && !(ev_i && tok_i == TOK_ACK && src_i == OWN)
        |=> q.st == CS_PENDING);

    // R8: a release never raises a port that is not active
    p_rel_no_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i && tok_i == TOK_REL && q.st != CS_ACTIVE |=> q.st == $past(q.st));

    // R9: an acknowledge addressed here wakes an inactive port toward its sender
    p_ack_partner_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i && tok_i == TOK_ACK && q.st == CS_INACTIVE && dst_i == OWN
        |=> q.st == CS_ACTIVE && q.partner == $past(src_i));

    // R10: own request acknowledged moves to active toward the destination
    p_own_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i && tok_i == TOK_ACK && q.st == CS_PENDING && src_i == OWN
        |=> q.st == CS_ACTIVE && q.partner == $past(dst_i));

    // R11: requests and unknown tokens have no effect on the tracker
    p_other_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i && tok_i != TOK_REL && tok_i != TOK_ACK
        |=> q.st == $past(q.st) && q.partner == $past(q.partner));

endmodule

// File: rtl/exn_port.sv
module exn_port
    import exn_pkg::*;
#(
    parameter int             IDW     = 5,
    parameter logic [IDW-1:0] ID      = 5'd6,
    parameter int             MSG_MAX = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ring_in_valid,
    output logic       ring_in_ready,
    input  logic [7:0] ring_in_data,
    output logic       ring_out_valid,
    input  logic       ring_out_ready,
    output logic [7:0] ring_out_data,
    input  logic       loc_in_valid,
    output logic       loc_in_ready,
    input  logic [7:0] loc_in_data,
    output logic       loc_out_valid,
    input  logic       loc_out_ready,
    output logic [7:0] loc_out_data,
    input  logic       xb_in_valid,
    output logic       xb_in_ready,
    input  logic [7:0] xb_in_data,
    output logic       xb_out_valid,
    input  logic       xb_out_ready,
    output logic [7:0] xb_out_data
);

    localparam int         AW  = (MSG_MAX > 1) ? $clog2(MSG_MAX) : 1;
    localparam int         LW  = $clog2(MSG_MAX + 1);
    localparam logic [7:0] OWN = 8'(ID);

    typedef struct packed {
        phase_e      ph;
        logic [8:0]  idx;
        logic [7:0]  len;
        logic [7:0]  dest;
        logic [LW-1:0] slen;
    } seq_t;

    seq_t q, d;

    logic          ring_stb;
    logic          ring_last;
    logic [7:0]    pk_tok, pk_a1, pk_a2, pk_src, pk_dst;
    logic          ev;
    logic          go_pend;
    logic          fire;
    conn_e         cst;
    logic [7:0]    partner;
    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    logic [AW-1:0] buf_raddr;
    logic [7:0]    buf_rdata;
    logic          xb_hs, loc_hs;
    logic          xb_last, loc_last;

    exn_ring_parse u_parse (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (ring_stb),
        .byte_i (ring_in_data),
        .last_o (ring_last),
        .tok_o  (pk_tok),
        .a1_o   (pk_a1),
        .a2_o   (pk_a2),
        .src_o  (pk_src),
        .dst_o  (pk_dst)
    );

    exn_conn_track #(.IDW(IDW), .ID(ID)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev),
        .tok_i     (pk_tok),
        .a1_i      (pk_a1),
        .a2_i      (pk_a2),
        .src_i     (pk_src),
        .dst_i     (pk_dst),
        .go_pend_i (go_pend),
        .st_o      (cst),
        .partner_o (partner),
        .fire_o    (fire)
    );

    exn_msg_buf #(.DEPTH(MSG_MAX), .AW(AW)) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (loc_in_data),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    // Message framing: byte 1 is the length, the last payload byte closes it
    assign xb_last  = (q.idx == 9'd1 && xb_in_data == 8'd0) ||
                      (q.idx >= 9'd2 && q.idx == {1'b0, q.len} + 9'd1);
    assign loc_last = (q.idx == 9'd1 && loc_in_data == 8'd0) ||
                      (q.idx >= 9'd2 && q.idx == {1'b0, q.len} + 9'd1);

    always_comb begin
        d              = q;
        ring_in_ready  = 1'b0;
        ring_out_valid = 1'b0;
        ring_out_data  = 8'h00;
        loc_in_ready   = 1'b0;
        loc_out_valid  = 1'b0;
        loc_out_data   = 8'h00;
        xb_in_ready    = 1'b0;
        xb_out_valid   = 1'b0;
        xb_out_data    = 8'h00;
        ring_stb       = 1'b0;
        ev             = 1'b0;
        go_pend        = 1'b0;
        buf_we         = 1'b0;
        buf_waddr      = AW'(q.idx - 9'd2);
        buf_raddr      = AW'(q.idx - 9'd2);
        xb_hs          = 1'b0;
        loc_hs         = 1'b0;

        case (q.ph)
            PH_IDLE: begin
                d.idx = 9'd0;
                if (xb_in_valid) begin
                    d.ph = PH_XB;
                end else if (ring_in_valid) begin
                    d.ph = PH_RING;
                end else if (loc_in_valid && cst != CS_PENDING) begin
                    d.ph = PH_LOC;
                end
            end

            PH_XB: begin
                loc_out_valid = xb_in_valid;
                loc_out_data  = xb_in_data;
                xb_in_ready   = loc_out_ready;
                xb_hs         = xb_in_valid && loc_out_ready;
                if (xb_hs) begin
                    if (q.idx == 9'd1) begin
                        d.len = xb_in_data;
                    end
                    if (xb_last) begin
                        d.ph  = PH_IDLE;
                        d.idx = 9'd0;
                    end else begin
                        d.idx = q.idx + 9'd1;
                    end
                end
            end

            PH_RING: begin
                ring_out_valid = ring_in_valid;
                ring_out_data  = ring_in_data;
                ring_in_ready  = ring_out_ready;
                ring_stb       = ring_in_valid && ring_out_ready;
                if (ring_stb && ring_last) begin
                    d.ph = PH_RING_ACT;
                end
            end

            PH_RING_ACT: begin
                ev    = 1'b1;
                d.idx = 9'd0;
                d.ph  = fire ? PH_SEND : PH_IDLE;
            end

            PH_LOC: begin
                loc_in_ready = 1'b1;
                loc_hs       = loc_in_valid;
                if (loc_hs) begin
                    if (q.idx == 9'd0) begin
                        d.dest = loc_in_data;
                    end
                    if (q.idx == 9'd1) begin
                        d.len  = loc_in_data;
                        d.slen = (loc_in_data > 8'(MSG_MAX)) ? LW'(MSG_MAX)
                                                             : LW'(loc_in_data);
                    end
                    if (q.idx >= 9'd2 && (q.idx - 9'd2) < 9'(MSG_MAX)) begin
                        buf_we = 1'b1;
                    end
                    if (loc_last) begin
                        d.ph  = PH_LOC_DEC;
                        d.idx = 9'd0;
                    end else begin
                        d.idx = q.idx + 9'd1;
                    end
                end
            end

            PH_LOC_DEC: begin
                d.idx = 9'd0;
                if (cst == CS_ACTIVE && q.dest == partner) begin
                    d.ph = PH_SEND;
                end else begin
                    go_pend = 1'b1;
                    d.ph    = PH_REQ;
                end
            end

            PH_REQ: begin
                ring_out_valid = 1'b1;
                case (q.idx)
                    9'd0:    ring_out_data = TOK_REQ;
                    9'd1:    ring_out_data = OWN;
                    default: ring_out_data = q.dest;
                endcase
                if (ring_out_ready) begin
                    if (q.idx == 9'd2) begin
                        d.ph  = PH_IDLE;
                        d.idx = 9'd0;
                    end else begin
                        d.idx = q.idx + 9'd1;
                    end
                end
            end

            PH_SEND: begin
                xb_out_valid = 1'b1;
                case (q.idx)
                    9'd0:    xb_out_data = OWN;
                    9'd1:    xb_out_data = 8'(q.slen);
                    default: xb_out_data = buf_rdata;
                endcase
                if (xb_out_ready) begin
                    if (q.idx == {{(9-LW){1'b0}}, q.slen} + 9'd1) begin
                        d.ph  = PH_IDLE;
                        d.idx = 9'd0;
                    end else begin
                        d.idx = q.idx + 9'd1;
                    end
                end
            end

            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ph   <= PH_IDLE;
            q.idx  <= '0;
            q.len  <= '0;
            q.dest <= '0;
            q.slen <= '0;
        end else begin
            q <= d;
        end
    end

    // R2: a waiting crossbar message wins the next arbitration
    p_xb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.ph == PH_IDLE && xb_in_valid |=> q.ph == PH_XB);

    // R2: local bytes are never taken while a request is outstanding
    p_no_loc_pend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cst == CS_PENDING |-> !loc_in_ready);

    // R5: a stalled crossbar byte is held until taken
    p_send_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xb_out_valid && !xb_out_ready && q.ph == PH_SEND
        |=> xb_out_valid && $stable(xb_out_data));

    // R6: a stalled request byte is held until taken
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ring_out_valid && !ring_out_ready && q.ph == PH_REQ
        |=> ring_out_valid && $stable(ring_out_data));

    // R7: the length sent into the crossbar never exceeds the buffer
    p_len_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.ph == PH_SEND && q.idx == 9'd1 |-> xb_out_data <= 8'(MSG_MAX));

    // R10: an acknowledged own request releases the stored message next
    p_fire_send_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ev && fire |=> q.ph == PH_SEND);

endmodule

// File: tb/exn_port_bench.sv
`timescale 1ns/1ps
module exn_port_bench;

    localparam logic [4:0] NODE = 5'd6;
    localparam logic [7:0] OWN8 = 8'd6;
    localparam int         MMAX = 16;
    localparam int         ST_INACT = 0;
    localparam int         ST_PEND  = 1;
    localparam int         ST_ACT   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_in_valid = 1'b0, ring_in_ready;
    logic [7:0] ring_in_data = 8'h00;
    logic ring_out_valid, ring_out_ready = 1'b1;
    logic [7:0] ring_out_data;
    logic loc_in_valid = 1'b0, loc_in_ready;
    logic [7:0] loc_in_data = 8'h00;
    logic loc_out_valid, loc_out_ready = 1'b1;
    logic [7:0] loc_out_data;
    logic xb_in_valid = 1'b0, xb_in_ready;
    logic [7:0] xb_in_data = 8'h00;
    logic xb_out_valid, xb_out_ready = 1'b1;
    logic [7:0] xb_out_data;

    always #2 clk = ~clk;

    exn_port #(.IDW(5), .ID(NODE), .MSG_MAX(MMAX)) u_exn_port (
        .clk(clk), .rst_n(rst_n),
        .ring_in_valid(ring_in_valid), .ring_in_ready(ring_in_ready), .ring_in_data(ring_in_data),
        .ring_out_valid(ring_out_valid), .ring_out_ready(ring_out_ready), .ring_out_data(ring_out_data),
        .loc_in_valid(loc_in_valid), .loc_in_ready(loc_in_ready), .loc_in_data(loc_in_data),
        .loc_out_valid(loc_out_valid), .loc_out_ready(loc_out_ready), .loc_out_data(loc_out_data),
        .xb_in_valid(xb_in_valid), .xb_in_ready(xb_in_ready), .xb_in_data(xb_in_data),
        .xb_out_valid(xb_out_valid), .xb_out_ready(xb_out_ready), .xb_out_data(xb_out_data)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit rand_rdy = 1'b0;
    logic [7:0] act_ring[$], act_loc[$], act_xb[$];
    logic [7:0] exp_ring[$], exp_loc[$], exp_xb[$];
    int t_ring_first = -1;
    int t_loc_first = -1;

    int m_st = ST_INACT;
    logic [7:0] m_partner = 8'hFF;
    logic [7:0] m_buf[$];

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            summary_and_end();
        end
    end

    always @(posedge clk) begin
        #1;
        if (rand_rdy) begin
            ring_out_ready = ($urandom_range(0, 3) != 0);
            loc_out_ready  = ($urandom_range(0, 3) != 0);
            xb_out_ready   = ($urandom_range(0, 3) != 0);
        end else begin
            ring_out_ready = 1'b1;
            loc_out_ready  = 1'b1;
            xb_out_ready   = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (ring_out_valid && ring_out_ready) begin
            act_ring.push_back(ring_out_data);
            if (t_ring_first < 0) t_ring_first = cyc;
        end
        if (loc_out_valid && loc_out_ready) begin
            act_loc.push_back(loc_out_data);
            if (t_loc_first < 0) t_loc_first = cyc;
        end
        if (xb_out_valid && xb_out_ready) act_xb.push_back(xb_out_data);
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp(input string tag, input string nm,
                       input logic [7:0] a[$], input logic [7:0] e[$]);
        int bad = -1;
        if (a.size() != e.size()) begin
            check(1'b0, tag, {nm, " byte count"}, a.size(), e.size());
            return;
        end
        foreach (e[i]) if (bad < 0 && a[i] !== e[i]) bad = i;
        if (bad >= 0) check(1'b0, tag, {nm, " byte"}, a[bad], e[bad]);
        else check(1'b1, tag, nm, 0, 0);
    endtask

    task automatic settle(input string tag);
        int w = 0;
        while ((act_ring.size() < exp_ring.size() || act_loc.size() < exp_loc.size() ||
                act_xb.size() < exp_xb.size()) && w < 4000) begin
            @(posedge clk);
            w++;
        end
        repeat (6) @(posedge clk);
        #1;
        cmp(tag, "ring", act_ring, exp_ring);
        cmp(tag, "sink", act_loc, exp_loc);
        cmp(tag, "xbar", act_xb, exp_xb);
        act_ring.delete(); act_loc.delete(); act_xb.delete();
        exp_ring.delete(); exp_loc.delete(); exp_xb.delete();
    endtask

    function automatic void set_v(input int ch, input logic v, input logic [7:0] b);
        case (ch)
            0: begin ring_in_valid = v; ring_in_data = b; end
            1: begin loc_in_valid = v; loc_in_data = b; end
            default: begin xb_in_valid = v; xb_in_data = b; end
        endcase
    endfunction

    function automatic logic get_r(input int ch);
        case (ch)
            0: return ring_in_ready;
            1: return loc_in_ready;
            default: return xb_in_ready;
        endcase
    endfunction

    task automatic put(input int ch, input logic [7:0] b);
        logic done = 1'b0;
        set_v(ch, 1'b1, b);
        while (!done) begin
            @(negedge clk);
            done = get_r(ch);
            @(posedge clk);
            #1;
        end
        set_v(ch, 1'b0, 8'h00);
    endtask

    task automatic put_seq(input int ch, input logic [7:0] s[$]);
        foreach (s[i]) put(ch, s[i]);
    endtask

    // ---- reference model computed from the requirements ----
    function automatic void m_local(input logic [7:0] dest, input logic [7:0] pl[$]);
        int sl = (pl.size() > MMAX) ? MMAX : pl.size();
        if (m_st == ST_ACT && dest == m_partner) begin                     // R5
            exp_xb.push_back(OWN8);
            exp_xb.push_back(8'(sl));
            for (int i = 0; i < sl; i++) exp_xb.push_back(pl[i]);
        end else begin                                                      // R6
            exp_ring.push_back(8'h01);
            exp_ring.push_back(OWN8);
            exp_ring.push_back(dest);
            m_st = ST_PEND;
            m_buf.delete();
            for (int i = 0; i < sl; i++) m_buf.push_back(pl[i]);
        end
    endfunction

    function automatic void m_ring(input logic [7:0] pk[$]);
        logic [7:0] src, dst;
        foreach (pk[i]) exp_ring.push_back(pk[i]);                         // R4
        if (pk[0] == 8'h03) begin                                           // R8
            if (m_st == ST_ACT && (pk[1] == OWN8 || pk[2] == OWN8 || pk[4] == OWN8) &&
                !(pk[3] == m_partner && pk[4] == OWN8)) m_st = ST_INACT;
        end else if (pk[0] == 8'h02) begin
            src = pk[1];
            dst = pk[2];
            if (m_st == ST_INACT && dst == OWN8) begin                      // R9
                m_st = ST_ACT;
                m_partner = src;
            end else if (m_st == ST_PEND && src == OWN8) begin              // R10
                exp_xb.push_back(OWN8);
                exp_xb.push_back(8'(m_buf.size()));
                foreach (m_buf[i]) exp_xb.push_back(m_buf[i]);
                m_st = ST_ACT;
                m_partner = dst;
            end
        end
    endfunction

    function automatic void mk_msg(input logic [7:0] hdr, input int len,
                                   output logic [7:0] all[$], output logic [7:0] pl[$]);
        all.delete(); pl.delete();
        all.push_back(hdr);
        all.push_back(8'(len));
        for (int i = 0; i < len; i++) pl.push_back(8'($urandom_range(0, 255)));
        foreach (pl[i]) all.push_back(pl[i]);
    endfunction

    task automatic tx_loc(input string tag, input logic [7:0] dest, input int len);
        logic [7:0] all[$], pl[$];
        mk_msg(dest, len, all, pl);
        m_local(dest, pl);
        put_seq(1, all);
        settle(tag);
    endtask

    task automatic tx_xb(input string tag, input logic [7:0] src, input int len);
        logic [7:0] all[$], pl[$];
        mk_msg(src, len, all, pl);
        foreach (all[i]) exp_loc.push_back(all[i]);                        // R3
        put_seq(2, all);
        settle(tag);
    endtask

    task automatic tx_ring(input string tag, input logic [7:0] pk[$]);
        m_ring(pk);
        put_seq(0, pk);
        settle(tag);
    endtask

    function automatic logic [7:0] pick();
        case ($urandom_range(0, 3))
            0: return OWN8;
            1: return m_partner;
            2: return 8'($urandom_range(0, 15));
            default: return 8'($urandom_range(0, 31));
        endcase
    endfunction

    initial begin
        logic [7:0] pk[$];
        logic [7:0] all[$], pl[$];
        logic [7:0] a_x[$], p_x[$], a_l[$], p_l[$];
        logic [7:0] rel[$];
        bit took;
        void'($urandom(32'h1357_2468));

        repeat (4) @(posedge clk);
        #1;
        // R1: no output valid while in reset and right after it
        check(!ring_out_valid && !loc_out_valid && !xb_out_valid, "R1", "valids in reset",
              {ring_out_valid, loc_out_valid, xb_out_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(!ring_out_valid && !loc_out_valid && !xb_out_valid, "R1", "valids after reset",
              {ring_out_valid, loc_out_valid, xb_out_valid}, 0);

        // R1: partner is nil and port inactive: message to 8'hFF becomes a request
        tx_loc("R1", 8'hFF, 4);
        // R10: own acknowledge releases the stored message
        pk = '{8'h02, OWN8, 8'd3};
        tx_ring("R10", pk);
        // R5: direct path to partner 3
        tx_loc("R5", 8'd3, 5);
        // R7: over-long message is trimmed
        tx_loc("R7", 8'd3, 21);
        tx_loc("R7", 8'd3, 0);
        // R3: crossbar traffic copied to sink, including empty and long payloads
        tx_xb("R3", 8'd11, 0);
        tx_xb("R3", 8'd2, 25);
        // R8: exception, sender is the partner and destination is this port
        pk = '{8'h03, OWN8, 8'd9, 8'd3, OWN8};
        tx_ring("R8", pk);
        tx_loc("R8", 8'd3, 2);
        // R8: partner B names this port: path dropped
        pk = '{8'h03, 8'd1, OWN8, 8'd9, 8'd1};
        tx_ring("R8", pk);
        tx_loc("R6", 8'd3, 3);

        // R2: while pending a held local byte is never taken
        took = 1'b0;
        loc_in_valid = 1'b1;
        loc_in_data = 8'd3;
        repeat (30) begin
            @(negedge clk);
            if (loc_in_ready) took = 1'b1;
        end
        @(posedge clk);
        #1;
        loc_in_valid = 1'b0;
        check(!took, "R2", "local taken while pending", took, 0);

        // R11: ack naming this port only as destination, request, unknown token
        pk = '{8'h02, 8'd5, OWN8};
        tx_ring("R11", pk);
        pk = '{8'h01, 8'd5, OWN8};
        tx_ring("R11", pk);
        pk = '{8'h7E};
        tx_ring("R4", pk);
        pk = '{8'h02, OWN8, 8'd4};
        tx_ring("R10", pk);
        tx_loc("R10", 8'd4, 1);

        // R9: drop path, then accept an incoming connection
        pk = '{8'h03, 8'd20, 8'd21, 8'd22, OWN8};
        tx_ring("R8", pk);
        pk = '{8'h02, 8'd12, OWN8};
        tx_ring("R9", pk);
        tx_loc("R9", 8'd12, 6);

        // R2: all three inputs at once while active toward 12
        mk_msg(8'd17, 3, a_x, p_x);
        mk_msg(8'd12, 2, a_l, p_l);
        rel = '{8'h03, OWN8, 8'd30, 8'd29, 8'd28};
        foreach (a_x[i]) exp_loc.push_back(a_x[i]);
        m_ring(rel);
        m_local(8'd12, p_l);
        t_ring_first = -1;
        t_loc_first = -1;
        fork
            put_seq(2, a_x);
            put_seq(0, rel);
            put_seq(1, a_l);
        join
        check(t_loc_first >= 0 && t_loc_first < t_ring_first, "R2", "crossbar before ring",
              t_loc_first, t_ring_first);
        settle("R2");
        pk = '{8'h02, OWN8, 8'd12};
        tx_ring("R10", pk);

        // random mix under random back-pressure
        rand_rdy = 1'b1;
        for (int it = 0; it < 140; it++) begin
            int kind = $urandom_range(0, 2);
            if (kind == 1 && m_st == ST_PEND) kind = 3;
            case (kind)
                0: tx_xb("R3", 8'($urandom_range(0, 31)), $urandom_range(0, 20));
                1: tx_loc("R5", ($urandom_range(0, 2) != 0) ? m_partner : pick(),
                          $urandom_range(0, 20));
                2: begin
                    case ($urandom_range(0, 3))
                        0: pk = '{8'h03, pick(), pick(), pick(), pick()};
                        1: pk = '{8'h01, pick(), pick()};
                        2: pk = '{8'h02, pick(), pick()};
                        default: pk = '{8'($urandom_range(8, 250))};
                    endcase
                    tx_ring("R4", pk);
                end
                default: begin
                    pk = '{8'h02, OWN8, pick()};
                    tx_ring("R10", pk);
                end
            endcase
        end
        rand_rdy = 1'b0;

        summary_and_end();
    end

endmodule